// File: doc/BRIEF.md
# Interrupt Mapping and Gating Controller

This block sits beside a PCI host bridge and decides which of its level-sensitive interrupt sources may reach the interrupt-vector lines. There are 48 source lines. Lines 0 to 31 come from PCI slots, and each group of four shares one PCI map register. Lines 32 to 47 come from on-board I/O sources, and each has its own I/O map register. Each map register holds a fixed interrupt number in bits 30:0 and an enable flag in bit 31. A source line reaches its output only while the governing enable flag is set.

Software uses a small register bus (address, write data, write strobe, combinational read data). Through it, software sets and clears enable flags and reads back the map registers. Two clear windows let software force a single output low without touching its enable. The forced-low state holds until the input level changes or the enable toggles.

Each output line is driven by a three-state machine. `LN_OFF` means the output is low and tracking. `LN_ON` means the output is high. `LN_SQUELCHED` means the output was forced low by a clear. An *event* is a change of the line's input, or a change of its enable flag, seen against the values registered one cycle earlier. A clear write moves any state to `LN_SQUELCHED`, and a clear takes priority over an event in the same cycle. Otherwise the following transitions apply on an event:
- `LN_OFF`→`LN_ON` when the enable and the input are both high.
- `LN_ON`→`LN_OFF` when either of them is low.
- `LN_SQUELCHED`→`LN_ON` or `LN_OFF`, depending on enable AND input.

Without an event, every state holds.

Top module: `irq_map_gate`

## Requirements
- R1: After reset every output is low and every enable flag is clear. Reads of PCI map register i return 0x7C0 | (i << 2), and reads of I/O map register i return 0x7E0 + i. A later reset clears the enable flags again and leaves these numbers unchanged.
- R2: PCI map register i (i = 0..7) is read and written at byte offset 0x0C04 + 8·i. Read data is {enable, 0x7C0 | (i << 2)}.
- R3: I/O map register i (i = 0..15) is read and written at byte offset 0x1004 + 8·i. Read data is {enable, 0x7E0 + i}.
- R4: A write to a map register copies write-data bit 31 into the enable flag. Write-data bits 30:0 are discarded, and the stored number never changes.
- R5: Inside the map windows (0x0C00–0x0C3F, 0x1000–0x1080), any address with bit 2 clear reads 0, and writes to it change nothing.
- R6: Line n < 32 is gated by PCI map register n >> 2. Line n ≥ 32 is gated by I/O map register n − 32.
- R7: While a line's enable is set, its output takes the new input level on the clock edge after the input changes. Without an input change, enable change or clear, the output holds.
- R8: While a line's enable is clear, its output is low. A write that clears or sets an enable updates the affected outputs on the second clock edge after the write is presented: the write edge plus one.
- R9: A write to 0x1404 + 8·j (j = 0..7) forces output j low on the write edge. The output stays low, even with its input still high, until its input changes or its enable toggles.
- R10: A write to 0x1804 + 8·j (j = 0..11) forces output 32 + j low on the write edge, with the same holding rule as R9.
- R11: When a clear write and an input change on the same line fall on the same edge, the clear wins and the output stays low.
- R12: Offsets outside the four windows read 0, and writes to them alter no enable and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte offset for read and write; bits 15:0 are decoded |
| bus_wdata | input | 32 | Write data; only bit 31 is stored |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_in | input | 48 | Level-sensitive source lines (0..31 PCI, 32..47 I/O) |
| irq_out | output | 48 | Gated interrupt-vector lines, registered |

## Verification
The hardest situation to reach from the ports is `LN_SQUELCHED` with the input held high. In that state the output must stay low, and it must leave the state only on a real event. The stimulus first enables a PCI group with all inputs high, then clears one line, then idles for a full step to show the line stays low. It then drops and raises that input to bring the line back. A second sequence presents an input rise and a clear of the same line in one write cycle, so that the clear-over-event priority is observed at the output. A mid-run reset, issued after several enables were set, shows that the flags are cleared while the stored numbers survive.

// File: rtl/irq_map_gate_pkg.sv
package irq_map_gate_pkg;

    // Register-bus windows (byte offsets in the low 16 address bits).
    localparam logic [15:0] PCI_MAP_LO = 16'h0C00;
    localparam logic [15:0] PCI_MAP_HI = 16'h0C3F;
    localparam logic [15:0] IO_MAP_LO  = 16'h1000;
    localparam logic [15:0] IO_MAP_HI  = 16'h1080;
    localparam logic [15:0] PCI_CLR_LO = 16'h1400;
    localparam logic [15:0] PCI_CLR_HI = 16'h143F;
    localparam logic [15:0] IO_CLR_LO  = 16'h1800;
    localparam logic [15:0] IO_CLR_HI  = 16'h1860;

    // Width of the register index carried from the decoder.
    localparam int WIN_IDX_W = 5;

    // Fixed interrupt-number bases held in bits 30:0 of the map registers.
    localparam logic [30:0] PCI_NUM_BASE = 31'h7C0;
    localparam logic [30:0] IO_NUM_BASE  = 31'h7E0;

    // First output line reached through the I/O clear window.
    localparam int IO_CLR_LINE_BASE = 32;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_PCI_MAP,
        WIN_IO_MAP,
        WIN_PCI_CLR,
        WIN_IO_CLR
    } win_e;

    typedef enum logic [1:0] {
        LN_OFF,
        LN_ON,
        LN_SQUELCHED
    } line_state_e;

endpackage

// File: rtl/irq_map_decode.sv
module irq_map_decode
    import irq_map_gate_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]    addr,
    output win_e                 win,
    output logic [WIN_IDX_W-1:0] idx
);

    logic [15:0] off;
    assign off = addr[15:0];

    // Only the word with address bit 2 set is live in every window.
    always_comb begin
        win = WIN_NONE;
        idx = '0;
        if (off[2]) begin
            if (off >= PCI_MAP_LO && off <= PCI_MAP_HI) begin
                win = WIN_PCI_MAP;
                idx = WIN_IDX_W'(off[5:3]);
            end else if (off >= IO_MAP_LO && off <= IO_MAP_HI) begin
                win = WIN_IO_MAP;
                idx = off[7:3];
            end else if (off >= PCI_CLR_LO && off <= PCI_CLR_HI) begin
                win = WIN_PCI_CLR;
                idx = WIN_IDX_W'(off[5:3]);
            end else if (off >= IO_CLR_LO && off <= IO_CLR_HI) begin
                win = WIN_IO_CLR;
                idx = off[7:3];
            end
        end
    end

endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_map_gate_pkg::*;
#(
    parameter int NUM_PCI_MAPS = 8,
    parameter int NUM_IO_MAPS  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_flag,
    input  win_e                    win,
    input  logic [WIN_IDX_W-1:0]    idx,
    output logic [NUM_PCI_MAPS-1:0] pci_en,
    output logic [NUM_IO_MAPS-1:0]  io_en,
    output logic [31:0]             rd_data
);

    localparam int PIDX_W = $clog2(NUM_PCI_MAPS);
    localparam int IIDX_W = $clog2(NUM_IO_MAPS);

    // Only the enable flags are storage; interrupt numbers are constants.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pci_en <= '0;
            io_en  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_PCI_MAPS; i++) begin
                if (win == WIN_PCI_MAP && idx == WIN_IDX_W'(i)) begin
                    pci_en[i] <= wr_flag;
                end
            end
            for (int i = 0; i < NUM_IO_MAPS; i++) begin
                if (win == WIN_IO_MAP && idx == WIN_IDX_W'(i)) begin
                    io_en[i] <= wr_flag;
                end
            end
        end
    end

    always_comb begin
        unique case (win)
            WIN_PCI_MAP: rd_data = {pci_en[idx[PIDX_W-1:0]],
                                    PCI_NUM_BASE | (31'(idx[PIDX_W-1:0]) << 2)};
            WIN_IO_MAP:  rd_data = {io_en[idx[IIDX_W-1:0]],
                                    IO_NUM_BASE + 31'(idx[IIDX_W-1:0])};
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate
    import irq_map_gate_pkg::*;
#(
    parameter int NUM_LINES = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] line_en,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] irq_out
);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        line_state_e st_q;
        line_state_e st_d;
        logic        in_q;
        logic        en_q;
        logic        ev;
        logic        pass;

        assign ev   = (irq_in[n] ^ in_q) | (line_en[n] ^ en_q);
        assign pass = irq_in[n] & line_en[n];

        // State register with the history used for event detection.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= LN_OFF;
                in_q <= 1'b0;
                en_q <= 1'b0;
            end else begin
                st_q <= st_d;
                in_q <= irq_in[n];
                en_q <= line_en[n];
            end
        end

        // Next state: a clear beats any event on the same edge.
        always_comb begin
            st_d = st_q;
            unique case (st_q)
                LN_OFF:       if (ev && pass)  st_d = LN_ON;
                LN_ON:        if (ev && !pass) st_d = LN_OFF;
                LN_SQUELCHED: if (ev)          st_d = pass ? LN_ON : LN_OFF;
                default:                       st_d = LN_OFF;
            endcase
            if (clr[n]) begin
                st_d = LN_SQUELCHED;
            end
        end

        assign irq_out[n] = (st_q == LN_ON);
    end

endmodule

// File: rtl/irq_map_gate.sv
module irq_map_gate
    import irq_map_gate_pkg::*;
#(
    parameter int ADDR_W            = 16,
    parameter int NUM_PCI_MAPS      = 8,
    parameter int NUM_IO_MAPS       = 32,
    parameter int PCI_LINES_PER_MAP = 4,
    parameter int NUM_IO_LINES      = 16,
    localparam int NUM_PCI_LINES    = NUM_PCI_MAPS * PCI_LINES_PER_MAP,
    localparam int NUM_LINES        = NUM_PCI_LINES + NUM_IO_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_we,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);

    win_e                    win;
    logic [WIN_IDX_W-1:0]    idx;
    logic [NUM_PCI_MAPS-1:0] pci_en;
    logic [NUM_IO_MAPS-1:0]  io_en;
    logic [NUM_LINES-1:0]    line_en;
    logic [NUM_LINES-1:0]    clr_vec;
    logic                    unused_bits;

    assign unused_bits = ^{bus_wdata[30:0], io_en[NUM_IO_MAPS-1:NUM_IO_LINES]};

    irq_map_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .win  (win),
        .idx  (idx)
    );

    irq_map_regs #(
        .NUM_PCI_MAPS (NUM_PCI_MAPS),
        .NUM_IO_MAPS  (NUM_IO_MAPS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_flag (bus_wdata[31]),
        .win     (win),
        .idx     (idx),
        .pci_en  (pci_en),
        .io_en   (io_en),
        .rd_data (bus_rdata)
    );

    // Per-line enable selection and clear strobes.
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_route
        if (n < NUM_PCI_LINES) begin : g_pci
            assign line_en[n] = pci_en[n / PCI_LINES_PER_MAP];
        end else begin : g_io
            assign line_en[n] = io_en[n - NUM_PCI_LINES];
        end
        assign clr_vec[n] = bus_we &&
            ((win == WIN_PCI_CLR && int'(idx) == n) ||
             (win == WIN_IO_CLR  && IO_CLR_LINE_BASE + int'(idx) == n));
    end

    irq_line_gate #(
        .NUM_LINES (NUM_LINES)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .line_en (line_en),
        .clr     (clr_vec),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irq_map_gate_chk.sv
module irq_map_gate_chk #(
    parameter int ADDR_W        = 16,
    parameter int NUM_LINES     = 48,
    parameter int NUM_PCI_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [NUM_LINES-1:0] line_en
);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // R7: a high output needs a high input on the previous sample.
        p_out_needs_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[n] |-> $past(irq_in[n]));
        // R8: a high output needs its enable on the previous sample.
        p_gate_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[n] |-> $past(line_en[n]));
    end

    for (genvar j = 0; j < 8; j++) begin : g_pci_clr
        p_pci_clear_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr[15:0] == 16'h1404 + 16'(8 * j)) |=> !irq_out[j]);
    end

    for (genvar j = 0; j < 12; j++) begin : g_io_clr
        p_io_clear_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr[15:0] == 16'h1804 + 16'(8 * j)) |=> !irq_out[NUM_PCI_LINES + j]);
    end

    // R7: with no writes and steady inputs the outputs hold.
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !$past(bus_we) && $stable(irq_in)) |=> $stable(irq_out));

endmodule

bind irq_map_gate irq_map_gate_chk #(
    .ADDR_W        (ADDR_W),
    .NUM_LINES     (NUM_LINES),
    .NUM_PCI_LINES (NUM_PCI_LINES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .line_en  (line_en)
);

// File: tb/test_irq_map_gate.sv
`timescale 1ns/1ps
module test_irq_map_gate;

    localparam int NL = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_in = '0;
    logic [NL-1:0] irq_out;

    always #4 clk = ~clk;

    irq_map_gate i_irq_map_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    typedef struct {
        int            due;
        logic [NL-1:0] exp_out;
        logic          rd_chk;
        logic [31:0]   exp_rd;
        string         req;
    } sb_item_t;

    sb_item_t sb[$];
    int       cyc = 0;
    int       n_run = 0;
    int       n_fail = 0;
    bit       done = 0;

    // Reference state, built from the requirements.
    logic [7:0]    pci_en_m = '0;
    logic [31:0]   io_en_m  = '0;
    logic [NL-1:0] out_m    = '0;
    logic [NL-1:0] in_m     = '0;

    function automatic logic en_of(int n);
        return (n < 32) ? pci_en_m[n >> 2] : io_en_m[n - 32];
    endfunction

    // Monitor: compare due items at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                sb_item_t it;
                it = sb.pop_front();
                n_run++;
                if (irq_out !== it.exp_out) begin
                    n_fail++;
                    $display("FAIL %s irq_out actual=%h expected=%h", it.req, irq_out, it.exp_out);
                end
                if (it.rd_chk) begin
                    n_run++;
                    if (bus_rdata !== it.exp_rd) begin
                        n_fail++;
                        $display("FAIL %s bus_rdata actual=%h expected=%h", it.req, bus_rdata, it.exp_rd);
                    end
                end
            end
        end
    end

    task automatic push(logic rd_chk, logic [31:0] exp_rd, string req);
        sb_item_t it;
        it.due = cyc + 1;
        it.exp_out = out_m;
        it.rd_chk = rd_chk;
        it.exp_rd = exp_rd;
        it.req = req;
        sb.push_back(it);
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    // One step: optional new inputs and optional write, presented together.
    task automatic step(logic [NL-1:0] new_in, logic we, logic [15:0] addr,
                        logic [31:0] data, string req);
        logic [NL-1:0] en_old;
        logic [NL-1:0] en_new;
        logic [NL-1:0] clr;
        clr = '0;
        for (int n = 0; n < NL; n++) en_old[n] = en_of(n);
        if (we && addr[2]) begin
            if (addr >= 16'h0C00 && addr <= 16'h0C3F) pci_en_m[addr[5:3]] = data[31];
            else if (addr >= 16'h1000 && addr <= 16'h1080) io_en_m[addr[7:3]] = data[31];
            else if (addr >= 16'h1400 && addr <= 16'h143F) clr[addr[5:3]] = 1'b1;
            else if (addr >= 16'h1800 && addr <= 16'h1860) clr[32 + int'(addr[7:3])] = 1'b1;
        end
        for (int n = 0; n < NL; n++) en_new[n] = en_of(n);
        // First edge: clears and input changes (old enable).
        for (int n = 0; n < NL; n++) begin
            if (clr[n]) out_m[n] = 1'b0;
            else if (new_in[n] != in_m[n]) out_m[n] = en_old[n] & new_in[n];
        end
        in_m = new_in;
        // Second edge: enable changes.
        for (int n = 0; n < NL; n++) begin
            if (en_new[n] != en_old[n]) out_m[n] = en_new[n] & in_m[n];
        end
        irq_in = new_in;
        bus_we = we;
        bus_addr = addr;
        bus_wdata = data;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        @(posedge clk);
        #1;
        push(1'b0, '0, req);
    endtask

    task automatic rd(logic [15:0] addr, logic [31:0] exp, string req);
        bus_we = 1'b0;
        bus_addr = addr;
        push(1'b1, exp, req);
    endtask

    task automatic do_reset(string req);
        rst_n = 1'b0;
        pci_en_m = '0;
        io_en_m = '0;
        out_m = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        push(1'b0, '0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    logic [NL-1:0] v;

    initial begin
        #1;
        do_reset("R1 reset outputs");
        rd(16'h0C04, 32'h0000_07C0, "R1 pci map0 number");
        rd(16'h0C3C, 32'h0000_07DC, "R1 pci map7 number");
        rd(16'h1004, 32'h0000_07E0, "R1 io map0 number");
        rd(16'h107C, 32'h0000_07EF, "R1 io map15 number");

        // R8: all inputs high, nothing enabled.
        v = '1;
        step(v, 1'b0, 16'h0, 32'h0, "R8 disabled stays low");

        // R2/R4/R6: enable PCI group 0 with junk in low bits.
        step(v, 1'b1, 16'h0C04, 32'hFFFF_FFFF, "R6 pci group0 enabled");
        rd(16'h0C04, 32'h8000_07C0, "R4 pci map0 number kept");
        step(v, 1'b1, 16'h0C1C, 32'h0000_1234, "R4 flag0 write");
        rd(16'h0C1C, 32'h0000_07CC, "R2 pci map3 readback");

        // R3/R6: I/O map 5 gates line 37.
        step(v, 1'b1, 16'h102C, 32'h8000_0000, "R6 io line37");
        rd(16'h102C, 32'h8000_07E5, "R3 io map5 readback");

        // R5: lower word ignored.
        step(v, 1'b1, 16'h0C08, 32'h8000_0000, "R5 lower word write ignored");
        rd(16'h0C08, 32'h0000_0000, "R5 lower word reads zero");
        rd(16'h0C0C, 32'h0000_07C4, "R5 upper word unchanged");

        // R7: follow input edges.
        v[2] = 1'b0;
        step(v, 1'b0, 16'h0, 32'h0, "R7 input fall");
        v[2] = 1'b1;
        step(v, 1'b0, 16'h0, 32'h0, "R7 input rise");

        // R9: clear line 1 while input held high.
        step(v, 1'b1, 16'h140C, 32'h0, "R9 clear line1");
        step(v, 1'b0, 16'h0, 32'h0, "R9 line1 stays low");
        v[1] = 1'b0;
        step(v, 1'b0, 16'h0, 32'h0, "R9 line1 input fall");
        v[1] = 1'b1;
        step(v, 1'b0, 16'h0, 32'h0, "R9 line1 returns");

        // R10: I/O clear reaches line 37.
        step(v, 1'b1, 16'h182C, 32'h0, "R10 clear line37");

        // R11: clear and input rise together on line 3.
        v[3] = 1'b0;
        step(v, 1'b0, 16'h0, 32'h0, "R11 line3 low first");
        v[3] = 1'b1;
        step(v, 1'b1, 16'h141C, 32'h0, "R11 clear beats rise");

        // R12: unmapped offsets.
        step(v, 1'b1, 16'h2004, 32'h8000_0000, "R12 unmapped write");
        rd(16'h2004, 32'h0, "R12 unmapped read");
        rd(16'h0C44, 32'h0, "R12 past pci window");

        // R6: top PCI group and last I/O line.
        step(v, 1'b1, 16'h0C3C, 32'h8000_0000, "R6 pci group7");
        step(v, 1'b1, 16'h107C, 32'h8000_0000, "R6 io line47");

        // R8: disable group 0.
        step(v, 1'b1, 16'h0C04, 32'h0, "R8 disable group0");

        // R1: second reset keeps numbers.
        do_reset("R1 second reset");
        rd(16'h0C3C, 32'h0000_07DC, "R1 pci map7 after reset");
        rd(16'h107C, 32'h0000_07EF, "R1 io map15 after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule